// File: doc/BRIEF.md
# MDIO Management Command Register

This block is a single 32-bit command register that runs a clause-22 management transaction on MDC/MDIO toward internal PHYs. Software writes one word carrying the operation, the PHY and register addresses, the write data, a run flag and an enable flag. The block then clocks out the full serial frame and clears the run flag when the frame ends. For a read, the halfword returned by the PHY appears in the low bits of the same register, so one location both launches the access and returns its result.

MDC is made from the system clock by a parameterised divider and is held low between frames. MDIO is presented as separate output, output-enable and input pins, so the pad logic outside the block forms the tri-state driver. Software polls the run flag. With the default settings a frame takes 512 system clocks, which is 10.24 us at 50 MHz, well inside the 20 us polling budget.

Top module: `mdio_cmd_master`

## Requirements
- R1: After reset the register reads 0, MDC is low and the MDIO output enable is low.
- R2: A write with bit 31 (run) and bit 30 (enable) both set starts a frame, and bit 31 reads 1 in the next cycle. The frame is sent MSB first, one bit per MDC period, with MDIO changing only when MDC falls. Its bits are 32 ones, start 01, opcode (01 write, 10 read), PHY address from bits [25:21], register address from bits [20:16], turnaround, then 16 data bits from bits [15:0].
- R3: When bit 27 is 1 the frame is a read. The output enable is low for the 2 turnaround bits and the 16 data bits. MDIO input is sampled at each rising MDC edge of the data bits, and when bit 31 clears, bits [15:0] hold the sampled halfword, first bit in bit 15.
- R4: Bit 31 clears exactly 2*CLK_HALF*(PRE_LEN+32) clocks after the edge that accepted the starting write. This is 512 clocks with the defaults.
- R5: A write with bit 31 set but bit 30 clear starts no frame. Bit 31 reads 0, MDC stays low, and the address, data and operation fields are still stored.
- R6: A write that arrives while bit 31 reads 1 is ignored. The frame in progress and the final register contents are unchanged.
- R7: MDC is low while idle. In a frame its first rise comes CLK_HALF clocks after the start, and each half period is CLK_HALF clocks. A write frame has turnaround 10 and keeps the output enable high for all PRE_LEN+32 bits.
- R8: Bits 29, 28 and 26 always read 0. Bits [15:0] of a write keep the written data after the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
The run flag is due one clock after the accepting write edge. The first MDC rise is due CLK_HALF clocks later, and the clear, with read data, comes at 2*CLK_HALF*(PRE_LEN+32) clocks. The bench counts falling system-clock edges from the write and records the exact count at which bit 31 first reads 0. It compares that count with the figure computed from the parameters. It samples MDIO and the output enable at the falling system-clock edge that follows each MDC rise, and it changes the PHY response bit at the same moment, a full MDC period before the block samples it.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned ADDR_W   = 5;
   localparam int unsigned DATA_W   = 16;
   localparam int unsigned BUSY_BIT = 31;
   localparam int unsigned EN_BIT   = 30;
   localparam int unsigned RD_BIT   = 27;
   localparam int unsigned PHY_LSB  = 21;
   localparam int unsigned REG_LSB  = 16;
   // start, opcode, two addresses, turnaround, data
   localparam int unsigned BODY_W   = 2 + 2 + 2*ADDR_W + 2 + DATA_W;

   typedef struct packed {
      logic              rd;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } mdio_cmd_t;
endpackage

// File: rtl/mdc_divider.sv
module mdc_divider #(
   parameter int unsigned CLK_HALF = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_tick,
   output logic fall_tick
);
   localparam int unsigned CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;

   logic term;

   if (CLK_HALF < 1) begin : g_bad_half
      $error("mdc_divider: CLK_HALF must be at least 1");
   end

   if (CLK_HALF == 1) begin : g_no_count
      assign term = run;
   end else begin : g_count
      localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          cnt <= '0;
         else if (!run)       cnt <= '0;
         else if (cnt == LAST) cnt <= '0;
         else                 cnt <= cnt + 1'b1;
      end
      assign term = run && (cnt == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mdc <= 1'b0;
      else if (!run)  mdc <= 1'b0;
      else if (term)  mdc <= ~mdc;
   end

   assign rise_tick = term && !mdc;
   assign fall_tick = term &&  mdc;
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter import mdio_cmd_pkg::*; #(
   parameter int unsigned PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  mdio_cmd_t         cmd,
   input  logic              rise_tick,
   input  logic              fall_tick,
   input  logic              mdio_in,
   output logic              active,
   output logic              done,
   output logic              mdio_out,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rx_data
);
   localparam int unsigned TOTAL = PRE_LEN + BODY_W;
   localparam int unsigned IDX_W = $clog2(TOTAL);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
   localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
   localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + 4 + 2*ADDR_W);
   localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + 6 + 2*ADDR_W);

   if (PRE_LEN < 1) begin : g_bad_pre
      $error("mdio_frame_shifter: PRE_LEN must be at least 1");
   end

   logic [IDX_W-1:0]  idx;
   logic [BODY_W-1:0] sh;
   logic              rd_q;
   logic [DATA_W-1:0] rx_sh;
   logic [BODY_W-1:0] body;
   logic              in_pre;

   always_comb begin
      body = {2'b01, (cmd.rd ? 2'b10 : 2'b01), cmd.phy, cmd.regad,
              (cmd.rd ? 2'b11 : 2'b10), (cmd.rd ? {DATA_W{1'b0}} : cmd.data)};
   end

   assign in_pre   = (idx < PRE_IDX);
   assign mdio_out = in_pre | sh[BODY_W-1];
   assign mdio_oe  = active && !(rd_q && (idx >= TA_IDX));
   assign done     = active && fall_tick && (idx == LAST_IDX);
   assign rx_data  = rx_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         sh     <= '0;
         rd_q   <= 1'b0;
         rx_sh  <= '0;
      end else if (start && !active) begin
         active <= 1'b1;
         idx    <= '0;
         sh     <= body;
         rd_q   <= cmd.rd;
         rx_sh  <= '0;
      end else if (active) begin
         if (rise_tick && rd_q && (idx >= DAT_IDX))
            rx_sh <= {rx_sh[DATA_W-2:0], mdio_in};
         if (fall_tick) begin
            if (idx == LAST_IDX) begin
               active <= 1'b0;
               idx    <= '0;
               sh     <= '0;
            end else begin
               idx <= idx + 1'b1;
               if (!in_pre) sh <= {sh[BODY_W-2:0], 1'b0};
            end
         end
      end
   end

   // MDIO moves only after a falling MDC edge inside a frame
   assert_out_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$stable(mdio_out)) |-> $past(fall_tick));

   // no read sample while the block itself drives the line
   assert_sample_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && rd_q && rise_tick && (idx >= DAT_IDX)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg import mdio_cmd_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_data,
   output logic [REG_W-1:0]  rd_data,
   output logic              start,
   output mdio_cmd_t         new_cmd,
   output logic              busy
);
   mdio_cmd_t cmd_q;
   logic      en_q;
   logic      busy_q;
   logic      accept;

   always_comb begin
      new_cmd.rd    = wr_data[RD_BIT];
      new_cmd.phy   = wr_data[PHY_LSB +: ADDR_W];
      new_cmd.regad = wr_data[REG_LSB +: ADDR_W];
      new_cmd.data  = wr_data[DATA_W-1:0];
   end

   assign accept = wr_en && !busy_q;
   assign start  = accept && wr_data[BUSY_BIT] && wr_data[EN_BIT];
   assign busy   = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         en_q   <= 1'b0;
         busy_q <= 1'b0;
      end else if (accept) begin
         cmd_q  <= new_cmd;
         en_q   <= wr_data[EN_BIT];
         busy_q <= start;
      end else if (done && busy_q) begin
         busy_q <= 1'b0;
         if (cmd_q.rd) cmd_q.data <= rx_data;
      end
   end

   always_comb begin
      rd_data                       = '0;
      rd_data[BUSY_BIT]             = busy_q;
      rd_data[EN_BIT]               = en_q;
      rd_data[RD_BIT]               = cmd_q.rd;
      rd_data[PHY_LSB +: ADDR_W]    = cmd_q.phy;
      rd_data[REG_LSB +: ADDR_W]    = cmd_q.regad;
      rd_data[DATA_W-1:0]           = cmd_q.data;
   end

   assert_start_needs_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> en_q);

   assert_busy_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && wr_en && !done) |=> (busy_q && $stable(cmd_q)));

   assert_busy_clears_on_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(done));
endmodule

// File: rtl/mdio_cmd_master.sv
module mdio_cmd_master import mdio_cmd_pkg::*; #(
   parameter int unsigned CLK_HALF = 4,
   parameter int unsigned PRE_LEN  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [31:0] wr_data,
   output logic [31:0] rd_data,
   output logic        mdc,
   output logic        mdio_out,
   output logic        mdio_oe,
   input  logic        mdio_in
);
   logic              start;
   logic              busy;
   logic              active;
   logic              done;
   logic              rise_tick;
   logic              fall_tick;
   logic [DATA_W-1:0] rx_data;
   mdio_cmd_t         new_cmd;

   mdio_cmd_reg u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .done    (done),
      .rx_data (rx_data),
      .rd_data (rd_data),
      .start   (start),
      .new_cmd (new_cmd),
      .busy    (busy)
   );

   mdc_divider #(.CLK_HALF(CLK_HALF)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (active),
      .mdc       (mdc),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   mdio_frame_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmd       (new_cmd),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick),
      .mdio_in   (mdio_in),
      .active    (active),
      .done      (done),
      .mdio_out  (mdio_out),
      .mdio_oe   (mdio_oe),
      .rx_data   (rx_data)
   );

   assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   assert_bus_released_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);
endmodule

// File: tb/mdio_cmd_master_tb.sv
module mdio_cmd_master_tb;
   localparam int HALF  = 4;
   localparam int PRE   = 32;
   localparam int TOTAL = PRE + 32;
   localparam int FRAME_CYC = 2 * HALF * TOTAL;
   localparam int NV = 4;
   // {rd, phy, reg, data, phy response}
   localparam logic [42:0] VEC [NV] = '{
      {1'b0, 5'h01, 5'h00, 16'h1140, 16'h0000},
      {1'b1, 5'h1F, 5'h02, 16'h0000, 16'h004D},
      {1'b0, 5'h00, 5'h1F, 16'hA5C3, 16'h0000},
      {1'b1, 5'h12, 5'h15, 16'h0000, 16'h8001}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic mdc, mdio_out, mdio_oe;
   logic mdio_in = 1'b1;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   mdio_cmd_master #(.CLK_HALF(HALF), .PRE_LEN(PRE)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .mdc(mdc), .mdio_out(mdio_out),
      .mdio_oe(mdio_oe), .mdio_in(mdio_in)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mkword(input logic run, input logic en, input logic rd,
                                          input logic [4:0] phy, input logic [4:0] rg,
                                          input logic [15:0] d);
      return {run, en, 2'b00, rd, 1'b0, phy, rg, d};
   endfunction

   // runs one frame; optional write injected mid-frame at cycle inj_n
   task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] rg,
                            input logic [15:0] d, input logic [15:0] resp,
                            input int inj_n, input logic [31:0] inj_word);
      logic [63:0] exp_bits, got_out, got_oe, exp_oe;
      int n, k, free_at, first_rise;
      logic prev;
      exp_bits = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                  (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : d)};
      exp_oe   = rd ? {{(TOTAL-18){1'b1}}, 18'h0} : {64{1'b1}};
      got_out = '0; got_oe = '0;
      @(negedge clk);
      wr_en = 1'b1; wr_data = mkword(1'b1, 1'b1, rd, phy, rg, d);
      @(negedge clk);
      wr_en = 1'b0;
      check("R2 busy set after start", 64'(rd_data[31]), 64'd1);
      n = 0; k = 0; free_at = -1; first_rise = -1; prev = mdc;
      while (n < FRAME_CYC + 20) begin
         if (mdc && !prev) begin
            if (first_rise < 0) first_rise = n;
            if (k < TOTAL) begin
               got_out[TOTAL-1-k] = mdio_out;
               got_oe[TOTAL-1-k]  = mdio_oe;
            end
            k++;
            if (k >= PRE + 16 && k < TOTAL) mdio_in = resp[15 - (k - PRE - 16)];
            else mdio_in = 1'b1;
         end
         prev = mdc;
         if (wr_en) wr_en = 1'b0;
         if (n == inj_n) begin
            wr_en = 1'b1; wr_data = inj_word;
         end
         if (rd_data[31] == 1'b0) begin
            free_at = n;
            break;
         end
         @(negedge clk);
         n++;
      end
      wr_en = 1'b0;
      check("R4 busy clear cycle", 64'(free_at), 64'(FRAME_CYC));
      check("R7 first MDC rise cycle", 64'(first_rise), 64'(HALF));
      check("R7 MDC rise count", 64'(k), 64'(TOTAL));
      if (rd) begin
         check("R3 read header bits", got_out[63:18], exp_bits[63:18]);
         check("R3 output enable released", got_oe, exp_oe);
         check("R3 read data returned", 64'(rd_data), 64'(mkword(1'b0, 1'b1, 1'b1, phy, rg, resp)));
      end else begin
         check("R2 write frame bits", got_out, exp_bits);
         check("R7 write output enable", got_oe, exp_oe);
         check("R8 write data kept", 64'(rd_data), 64'(mkword(1'b0, 1'b1, 1'b0, phy, rg, d)));
      end
      check("R7 MDC low after frame", 64'(mdc), 64'd0);
   endtask

   initial begin
      #(20 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] w;
      repeat (3) @(negedge clk);
      check("R1 reset register", 64'(rd_data), 64'd0);
      check("R1 reset mdc", 64'(mdc), 64'd0);
      check("R1 reset oe", 64'(mdio_oe), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         run_frame(VEC[i][42], VEC[i][41:37], VEC[i][36:32], VEC[i][31:16], VEC[i][15:0],
                   -1, 32'h0);
      end

      // R5 and R8: run without enable, reserved bits written as ones
      w = 32'hB400_0000 | (32'(5'h0A) << 21) | (32'(5'h03) << 16) | 32'h1234;
      @(negedge clk);
      wr_en = 1'b1; wr_data = w;
      @(negedge clk);
      wr_en = 1'b0;
      check("R5 R8 no start, fields kept, reserved zero", 64'(rd_data),
            64'(mkword(1'b0, 1'b0, 1'b0, 5'h0A, 5'h03, 16'h1234)));
      repeat (3 * HALF) @(negedge clk);
      check("R5 mdc idle without enable", 64'(mdc), 64'd0);
      check("R5 oe idle without enable", 64'(mdio_oe), 64'd0);

      // R6: write during a frame is ignored
      run_frame(1'b0, 5'h07, 5'h09, 16'h5A5A, 16'h0,
                100, mkword(1'b1, 1'b1, 1'b1, 5'h1B, 5'h1C, 16'hFFFF));
      check("R6 idle after ignored write", 64'(rd_data[31]), 64'd0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule